// File: doc/BRIEF.md
# Write-coalescing command buffer encoder

This block builds a command buffer in a local RAM from a stream of register write requests, each an offset and a 32-bit value. Each instruction occupies a pair of words starting at an even position. A write whose offset differs from that of the previous instruction becomes a direct write. A write to the same offset as the previous instruction is merged into one indexed write. The first time this happens, the block rewrites the earlier direct write where it stands.

A finish request zero-fills the buffer up to the next 16-word boundary and publishes the tail as a byte address. That address is ready for a later submission step, which is outside this block. A request that arrives when fewer than two free words remain is rejected and raises a sticky overflow flag. A clear input empties the buffer. A combinational read port exposes any word of the buffer.

Each accepted request runs as a sequence of single-word RAM writes. The ready output is low while such a sequence is in progress.

Top module: `wr_coalesce_enc`

## Requirements
- R1: A direct write places the value in the even word `a` and the header `{8'h01, 4'hF, offset[19:0]}` in word `a+1`, then leaves the free position at `a+2`.
- R2: A new instruction starts at the free position rounded up to even. A word skipped by this rounding is left unchanged.
- R3: A write to the same offset as a preceding direct write at word `s` rewrites that instruction in place. The result is word `s` = 2, word `s+1` = `{8'h09, 4'h0, offset}`, word `s+2` = old value and word `s+3` = new value, with the free position at `s+4`.
- R4: A write to the same offset as a preceding indexed write stores the value at the free position, advances the free position by one, and increments the count in the instruction's first word.
- R5: After an append that leaves the free position odd, the word at the free position is set to zero and the free position does not move.
- R6: A write to a different offset ends the merging and emits a new direct write.
- R7: A request that arrives while the free position is greater than SIZE_WORDS-2 is rejected. It sets `ovf_o`, which stays set, and leaves the free position and the buffer unchanged. The free position never exceeds SIZE_WORDS.
- R8: Finish writes zero from the free position up to the next multiple of 16 words and moves the free position there. It then sets `tail_o` to the free position times 4. A finish at a position that is already aligned changes nothing.
- R9: After a finish, the next write emits a direct write even when its offset matches the last instruction.
- R10: Clear sets the free position and the instruction start to 0, forgets the previous instruction and clears `ovf_o`.
- R11: After reset, `ready_o` = 1, `fp_o` = 0, `tail_o` = 0 and `ovf_o` = 0. `ready_o` is low from the cycle after an accepted request until its sequence completes.
- R12: `rd_data_o` shows the buffer word at `rd_addr_i` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Empty the buffer and forget history |
| req_valid_i | input | 1 | Write request, taken when ready_o is high |
| req_off_i | input | 20 | Register offset of the request |
| req_val_i | input | 32 | Value of the request |
| finish_i | input | 1 | Pad to the line boundary and publish the tail; wins over req_valid_i |
| ready_o | output | 1 | Idle and able to take a request |
| ovf_o | output | 1 | Sticky overflow flag |
| fp_o | output | 7 | Free position in words |
| tail_o | output | 9 | Tail byte address from the last finish |
| rd_addr_i | input | 6 | Read port word address |
| rd_data_o | output | 32 | Read port data |

## Verification
The bench first fills the buffer with nonzero data and then clears it. This makes every zero that padding, the odd-position fill and the skipped word depend on visible. A design that forgot the pad word, or that wrote over the skipped word, would leave stale data or erase it.

The bench merges twice in a row, so that the count reaches 3 and 4 and the data words land one by one at odd and even positions. A rewrite that lost the old value or miscounted would show up in those words.

The bench runs finish twice, and then writes to the same offset right after padding. A design that kept merging across a finish would append into the padded line instead of emitting a direct write.

The bench fills the buffer exactly to its limit and probes the request just before the limit and the one past it. This exposes an off-by-one in the overflow bound, and also a rejected request that still rewrote the last instruction.

// File: rtl/wr_coalesce_pkg.sv
package wr_coalesce_pkg;
  localparam int OFF_W = 20;
  localparam int DW    = 32;
  localparam logic [7:0] OPC_DIRECT  = 8'h01;
  localparam logic [7:0] OPC_INDEXED = 8'h09;
  localparam logic [3:0] BE_ALL      = 4'hF;

  typedef enum logic [1:0] {PK_NONE, PK_DIRECT, PK_INDEXED} prev_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_DIR_LO, S_DIR_HI,
    S_RW_HDR, S_RW_OLD, S_RW_NEW, S_RW_CNT,
    S_APP_VAL, S_APP_CNT, S_APP_PAD,
    S_PAD
  } seq_st_e;

  function automatic logic [DW-1:0] make_hdr(input logic [7:0] opc,
                                             input logic [3:0] be,
                                             input logic [OFF_W-1:0] off);
    return {opc, be, off};
  endfunction
endpackage

// File: rtl/wr_coalesce_ram.sv
module wr_coalesce_ram #(
  parameter int WORDS = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/wr_coalesce_seq.sv
module wr_coalesce_seq
  import wr_coalesce_pkg::*;
#(
  parameter int SIZE_WORDS = 64,
  parameter int LINE_WORDS = 16,
  localparam int AW      = $clog2(SIZE_WORDS),
  localparam int PW      = AW + 1,
  localparam int LINE_LG = $clog2(LINE_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             req_valid_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [DW-1:0]    req_val_i,
  input  logic             finish_i,
  output logic             ready_o,
  output logic             ovf_o,
  output logic [PW-1:0]    fp_o,
  output logic [PW+1:0]    tail_o,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [DW-1:0]    wdata_o
);
  localparam logic [PW-1:0] LIMIT = PW'(SIZE_WORDS - 2);

  seq_st_e          st_q;
  prev_kind_e       prev_q;
  logic [PW-1:0]    fp_q;
  logic [AW-1:0]    ins_q;
  logic [OFF_W-1:0] off_q, prev_off_q;
  logic [DW-1:0]    val_q, last_val_q, cnt_q;
  logic             ovf_q;
  logic [PW+1:0]    tail_q;
  logic [PW-1:0]    fp_even;
  logic             same_off, line_done;

  assign fp_even   = fp_q + PW'(fp_q[0]);
  assign same_off  = (prev_off_q == req_off_i);
  assign line_done = (fp_q[LINE_LG-1:0] == '0);

  always_comb begin
    we_o    = 1'b1;
    waddr_o = ins_q;
    wdata_o = '0;
    unique case (st_q)
      S_DIR_LO:  wdata_o = val_q;
      S_DIR_HI:  begin waddr_o = ins_q + AW'(1); wdata_o = make_hdr(OPC_DIRECT, BE_ALL, off_q); end
      S_RW_HDR:  begin waddr_o = ins_q + AW'(1); wdata_o = make_hdr(OPC_INDEXED, 4'h0, off_q); end
      S_RW_OLD:  begin waddr_o = ins_q + AW'(2); wdata_o = last_val_q; end
      S_RW_NEW:  begin waddr_o = ins_q + AW'(3); wdata_o = val_q; end
      S_RW_CNT:  wdata_o = DW'(2);
      S_APP_VAL: begin waddr_o = fp_q[AW-1:0]; wdata_o = val_q; end
      S_APP_CNT: wdata_o = cnt_q + DW'(1);
      S_APP_PAD: waddr_o = fp_q[AW-1:0];
      S_PAD:     begin we_o = !line_done; waddr_o = fp_q[AW-1:0]; end
      default:   we_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; prev_q <= PK_NONE; fp_q <= '0; ins_q <= '0;
      off_q <= '0; prev_off_q <= '0; val_q <= '0; last_val_q <= '0;
      cnt_q <= '0; ovf_q <= 1'b0; tail_q <= '0;
    end else if (clear_i) begin
      st_q <= S_IDLE; prev_q <= PK_NONE; fp_q <= '0; ins_q <= '0; ovf_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (finish_i) begin
            prev_q <= PK_NONE;
            st_q   <= S_PAD;
          end else if (req_valid_i) begin
            if (fp_q > LIMIT) begin
              ovf_q <= 1'b1;
            end else begin
              off_q <= req_off_i;
              val_q <= req_val_i;
              if (prev_q == PK_DIRECT && same_off)       st_q <= S_RW_HDR;
              else if (prev_q == PK_INDEXED && same_off) st_q <= S_APP_VAL;
              else begin
                ins_q <= fp_even[AW-1:0];
                st_q  <= S_DIR_LO;
              end
            end
          end
        end
        S_DIR_LO: st_q <= S_DIR_HI;
        S_DIR_HI: begin
          fp_q       <= PW'(ins_q) + PW'(2);
          prev_q     <= PK_DIRECT;
          prev_off_q <= off_q;
          last_val_q <= val_q;
          st_q       <= S_IDLE;
        end
        S_RW_HDR: st_q <= S_RW_OLD;
        S_RW_OLD: st_q <= S_RW_NEW;
        S_RW_NEW: st_q <= S_RW_CNT;
        S_RW_CNT: begin
          fp_q   <= PW'(ins_q) + PW'(4);
          cnt_q  <= DW'(2);
          prev_q <= PK_INDEXED;
          st_q   <= S_IDLE;
        end
        S_APP_VAL: begin
          fp_q <= fp_q + PW'(1);
          st_q <= S_APP_CNT;
        end
        S_APP_CNT: begin
          cnt_q <= cnt_q + DW'(1);
          st_q  <= fp_q[0] ? S_APP_PAD : S_IDLE;
        end
        S_APP_PAD: st_q <= S_IDLE;
        S_PAD: begin
          if (line_done) begin
            tail_q <= {fp_q, 2'b00};
            st_q   <= S_IDLE;
          end else begin
            fp_q <= fp_q + PW'(1);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ready_o = (st_q == S_IDLE);
  assign ovf_o   = ovf_q;
  assign fp_o    = fp_q;
  assign tail_o  = tail_q;
endmodule

// File: rtl/wr_coalesce_enc.sv
module wr_coalesce_enc
  import wr_coalesce_pkg::*;
#(
  parameter int SIZE_WORDS = 64,
  parameter int LINE_WORDS = 16,
  localparam int AW = $clog2(SIZE_WORDS),
  localparam int PW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             req_valid_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [DW-1:0]    req_val_i,
  input  logic             finish_i,
  output logic             ready_o,
  output logic             ovf_o,
  output logic [PW-1:0]    fp_o,
  output logic [PW+1:0]    tail_o,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [DW-1:0]    rd_data_o
);
  logic          we;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;

  wr_coalesce_seq #(.SIZE_WORDS(SIZE_WORDS), .LINE_WORDS(LINE_WORDS)) u_seq (
    .clk_i, .rst_ni, .clear_i, .req_valid_i, .req_off_i, .req_val_i, .finish_i,
    .ready_o, .ovf_o, .fp_o, .tail_o,
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata)
  );

  wr_coalesce_ram #(.WORDS(SIZE_WORDS), .DW(DW)) u_ram (
    .clk_i, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/wr_coalesce_enc_chk.sv
module wr_coalesce_enc_chk #(
  parameter int SIZE_WORDS = 64,
  parameter int LINE_WORDS = 16,
  localparam int AW      = $clog2(SIZE_WORDS),
  localparam int PW      = AW + 1,
  localparam int LINE_LG = $clog2(LINE_WORDS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clear_i,
  input logic          req_valid_i,
  input logic          finish_i,
  input logic          ready_o,
  input logic          ovf_o,
  input logic [PW-1:0] fp_o,
  input logic [PW+1:0] tail_o
);
  localparam logic [PW-1:0] LIMIT = PW'(SIZE_WORDS - 2);

  // R11
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_valid_i && !finish_i && !clear_i && fp_o <= LIMIT) |=> !ready_o);

  // R7
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(ready_o && req_valid_i && !finish_i && fp_o > LIMIT));

  // R7
  ovf_no_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_valid_i && !finish_i && !clear_i && fp_o > LIMIT) |=> $stable(fp_o));

  // R7
  fp_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_o <= PW'(SIZE_WORDS));

  // R10
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (fp_o == '0 && !ovf_o && ready_o));

  // R8
  tail_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tail_o) |-> (tail_o[LINE_LG+1:0] == '0));

  // R8
  fp_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clear_i) |-> (fp_o >= $past(fp_o)));
endmodule

bind wr_coalesce_enc wr_coalesce_enc_chk #(.SIZE_WORDS(SIZE_WORDS), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .req_valid_i(req_valid_i),
  .finish_i(finish_i), .ready_o(ready_o), .ovf_o(ovf_o), .fp_o(fp_o), .tail_o(tail_o)
);

// File: tb/wr_coalesce_enc_tb.sv
module wr_coalesce_enc_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [19:0] req_off_i = '0;
  logic [31:0] req_val_i = '0;
  logic        finish_i = 1'b0;
  logic        ready_o, ovf_o;
  logic [6:0]  fp_o;
  logic [8:0]  tail_o;
  logic [5:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  wr_coalesce_enc u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_mem(input string tag, input int addr, input logic [31:0] exp);
    rd_addr_i = 6'(addr);
    #1;
    chk(tag, rd_data_o, exp);
  endtask

  task automatic wait_ready();
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
  endtask

  task automatic do_write(input logic [19:0] off, input logic [31:0] val);
    wait_ready();
    req_off_i = off; req_val_i = val; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    while (!ready_o) @(negedge clk_i);
  endtask

  task automatic do_finish();
    wait_ready();
    finish_i = 1'b1;
    @(negedge clk_i);
    finish_i = 1'b0;
    while (!ready_o) @(negedge clk_i);
  endtask

  task automatic do_clear();
    @(negedge clk_i);
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
  endtask

  function automatic logic [31:0] hdr_d(input logic [19:0] off);
    return {8'h01, 4'hF, off};
  endfunction
  function automatic logic [31:0] hdr_i(input logic [19:0] off);
    return {8'h09, 4'h0, off};
  endfunction

  task automatic t_reset();
    chk("R11 reset ready", 32'(ready_o), 32'd1);
    chk("R11 reset fp", 32'(fp_o), 32'd0);
    chk("R11 reset tail", 32'(tail_o), 32'd0);
    chk("R11 reset ovf", 32'(ovf_o), 32'd0);
  endtask

  task automatic t_prefill();
    for (int i = 0; i < 8; i++) do_write(20'h400 + 20'(i), 32'hA5A5_0000 + 32'(i));
    chk("R10 prefill fp", 32'(fp_o), 32'd16);
    do_clear();
    chk("R10 clear fp", 32'(fp_o), 32'd0);
  endtask

  task automatic t_direct();
    wait_ready();
    req_off_i = 20'h00100; req_val_i = 32'h1111_0001; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R11 busy after accept", 32'(ready_o), 32'd0);
    while (!ready_o) @(negedge clk_i);
    chk_mem("R1 value word", 0, 32'h1111_0001);
    chk_mem("R1 header word", 1, hdr_d(20'h00100));
    chk("R1 fp", 32'(fp_o), 32'd2);
    chk_mem("R12 read port untouched word", 2, 32'hA5A5_0001);
  endtask

  task automatic t_merge();
    do_write(20'h00100, 32'h1111_0002);
    chk_mem("R3 count", 0, 32'd2);
    chk_mem("R3 indexed header", 1, hdr_i(20'h00100));
    chk_mem("R3 old value", 2, 32'h1111_0001);
    chk_mem("R3 new value", 3, 32'h1111_0002);
    chk("R3 fp", 32'(fp_o), 32'd4);
    do_write(20'h00100, 32'h1111_0003);
    chk_mem("R4 appended", 4, 32'h1111_0003);
    chk_mem("R4 count 3", 0, 32'd3);
    chk("R5 fp odd", 32'(fp_o), 32'd5);
    chk_mem("R5 pad zero", 5, 32'd0);
    do_write(20'h00100, 32'h1111_0004);
    chk_mem("R4 appended even", 5, 32'h1111_0004);
    chk_mem("R4 count 4", 0, 32'd4);
    chk("R4 fp", 32'(fp_o), 32'd6);
  endtask

  task automatic t_break();
    do_write(20'h00200, 32'h2222_0001);
    chk_mem("R6 new direct value", 6, 32'h2222_0001);
    chk_mem("R6 new direct header", 7, hdr_d(20'h00200));
    chk_mem("R6 previous count kept", 0, 32'd4);
    do_write(20'h00200, 32'h2222_0002);
    do_write(20'h00200, 32'h2222_0003);
    chk("R5 fp odd again", 32'(fp_o), 32'd11);
    chk_mem("R5 pad at 11", 11, 32'd0);
    chk_mem("R4 count at 6", 6, 32'd3);
    do_write(20'h00300, 32'h3333_0001);
    chk_mem("R2 aligned value", 12, 32'h3333_0001);
    chk_mem("R2 aligned header", 13, hdr_d(20'h00300));
    chk_mem("R2 skipped word", 11, 32'd0);
    chk_mem("R2 last data kept", 10, 32'h2222_0003);
    chk("R2 fp", 32'(fp_o), 32'd14);
  endtask

  task automatic t_finish();
    do_finish();
    chk_mem("R8 pad 14", 14, 32'd0);
    chk_mem("R8 pad 15", 15, 32'd0);
    chk("R8 fp boundary", 32'(fp_o), 32'd16);
    chk("R8 tail", 32'(tail_o), 32'd64);
    do_finish();
    chk("R8 aligned finish fp", 32'(fp_o), 32'd16);
    chk("R8 aligned finish tail", 32'(tail_o), 32'd64);
    do_write(20'h00300, 32'h3333_0002);
    chk_mem("R9 direct value", 16, 32'h3333_0002);
    chk_mem("R9 direct header", 17, hdr_d(20'h00300));
    chk_mem("R9 old instr untouched", 12, 32'h3333_0001);
    chk("R9 fp", 32'(fp_o), 32'd18);
    do_finish();
    chk("R8 fp second line", 32'(fp_o), 32'd32);
    chk("R8 tail second line", 32'(tail_o), 32'd128);
    chk_mem("R8 pad 31", 31, 32'd0);
  endtask

  task automatic t_overflow();
    do_clear();
    for (int i = 0; i < 31; i++) do_write(20'h00800 + 20'(i), 32'(i + 1));
    chk("R7 fp at limit", 32'(fp_o), 32'd62);
    chk("R7 no ovf at limit", 32'(ovf_o), 32'd0);
    do_write(20'h0081F, 32'd32);
    chk("R7 last fit fp", 32'(fp_o), 32'd64);
    chk("R7 no ovf last fit", 32'(ovf_o), 32'd0);
    do_write(20'h00900, 32'hDEAD_0001);
    chk("R7 ovf set", 32'(ovf_o), 32'd1);
    chk("R7 fp unchanged", 32'(fp_o), 32'd64);
    do_write(20'h0081F, 32'hDEAD_0002);
    chk("R7 ovf sticky", 32'(ovf_o), 32'd1);
    chk_mem("R7 last value kept", 62, 32'd32);
    chk_mem("R7 last header kept", 63, hdr_d(20'h0081F));
    do_clear();
    chk("R10 ovf cleared", 32'(ovf_o), 32'd0);
    chk("R10 fp cleared", 32'(fp_o), 32'd0);
    do_write(20'h0081F, 32'h5555_0001);
    chk_mem("R10 history dropped value", 0, 32'h5555_0001);
    chk_mem("R10 history dropped header", 1, hdr_d(20'h0081F));
    chk("R10 fp after", 32'(fp_o), 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_prefill();
    t_direct();
    t_merge();
    t_break();
    t_finish();
    t_overflow();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule